// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block tracks fixed interrupts for one processor core. Requests come in as a vector number with a trigger mode, and are held in a 256-bit pending register. A 256-bit trigger-mode register records the trigger mode of each vector. When the core takes an interrupt, its vector moves into a 256-bit in-service register. The block derives a processor priority from a software-written task priority and the highest vector now being serviced. It drives a registered interrupt line whenever a pending request has a higher priority class than that processor priority.

The core uses an acknowledge pulse to collect the vector it should service. When every pending request is held back by priority, the acknowledge returns a programmable spurious vector instead. An end-of-interrupt pulse retires the highest in-service vector. If that vector was level-triggered, and broadcast is not suppressed, the block pulses an end-of-interrupt broadcast carrying the vector, so that upstream sources can re-sample their lines. Bus decoding, timers and delivery between processors live elsewhere.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When `req_valid` is high, the bit `req_vector` of the pending register is set. The trigger-mode bit of that vector is set if `req_level` is 1 and cleared if it is 0. A later request for the same vector overwrites the trigger-mode bit.
- R2: The highest pending or in-service vector is the most significant set bit of its register, across all 32-bit word boundaries.
- R3: `ppr_out` equals the task priority when the task priority class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it equals that class followed by four zero bits. An empty in-service register counts as vector 0.
- R4: A pending request is deliverable when the processor priority is zero, or when the class of the highest pending vector is strictly greater than the processor priority class. A request of equal class is blocked.
- R5: When `ack_req` is high and a request is deliverable, the following clock shows `ack_valid`=1, `ack_kind`=1 (vector) and the vector. That vector leaves the pending register and enters the in-service register.
- R6: When `ack_req` is high, requests are pending and all of them are blocked, the response is `ack_kind`=2 (spurious) with the low 8 bits of the spurious register. No register bit changes.
- R7: When `ack_req` is high and nothing is pending, the response is `ack_kind`=0 (none) with vector 0.
- R8: `eoi_req` clears the highest in-service bit, and `ppr_out` is recomputed from the bits that remain.
- R9: When end-of-interrupt retires a vector whose trigger-mode bit is set, and `bcast_suppress` is low, the next clock shows a one-cycle `bcast_valid` pulse with that vector on `bcast_vector`. In every other case no pulse appears.
- R10: `svr_wdata` is 9 bits: [7:0] is the spurious vector and [8] is the software enable. While the enable is 0, `irq_out` stays low and an acknowledge returns kind 0 without changing any state.
- R11: `irq_out` and `ppr_out` are registered. They reflect a change of state, including a task priority write, on the second rising edge after the change is sampled.
- R12: Synchronous reset clears all three vector registers and the task priority. It sets the spurious register to 0x0FF, which leaves the block disabled. It drives all outputs low.
- R13: An end-of-interrupt with an empty in-service register changes nothing and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Accept an interrupt request this cycle |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| tpr_we | input | 1 | Write the task priority |
| tpr_wdata | input | 8 | Task priority value |
| svr_we | input | 1 | Write the spurious/enable register |
| svr_wdata | input | 9 | [8] enable, [7:0] spurious vector |
| bcast_suppress | input | 1 | Suppress the end-of-interrupt broadcast |
| ack_req | input | 1 | Acknowledge pulse from the core |
| eoi_req | input | 1 | End-of-interrupt pulse |
| irq_out | output | 1 | Registered interrupt line to the core |
| ppr_out | output | 8 | Registered processor priority |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_kind | output | 2 | 0 none, 1 vector, 2 spurious |
| ack_vector | output | 8 | Vector returned by the acknowledge |
| bcast_valid | output | 1 | End-of-interrupt broadcast pulse |
| bcast_vector | output | 8 | Vector carried by the broadcast |

## Verification
A bit left set in the in-service register shows up two cycles later, as a processor priority that stays too high on `ppr_out` and as an `irq_out` that stays low. A lost or duplicated pending bit shows up on the next acknowledge, as a wrong vector or a wrong spurious/none kind. A wrong trigger-mode bit stays hidden until its vector is retired, and then shows as a missing or extra broadcast pulse one cycle after the end-of-interrupt. For this reason the stimulus takes vectors all the way from request through acknowledge to retirement, so that every stored bit reaches a port.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    ACK_NONE     = 2'd0,
    ACK_VECTOR   = 2'd1,
    ACK_SPURIOUS = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/ipc_top_bit.sv
// Finds the most significant set bit of a wide vector, word by word.
module ipc_top_bit #(
  parameter int WIDTH  = 256,
  parameter int WORD_W = 32,
  parameter int IW     = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec,
  output logic             found,
  output logic [IW-1:0]    idx
);
  localparam int NWORDS = WIDTH / WORD_W;
  localparam int BW     = $clog2(WORD_W);

  logic [NWORDS-1:0]         word_any;
  logic [NWORDS-1:0][BW-1:0] word_pos;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [BW-1:0] pos;
    always_comb begin
      pos = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (vec[w*WORD_W + b]) pos = BW'(b);
      end
    end
    assign word_pos[w] = pos;
    assign word_any[w] = |vec[w*WORD_W +: WORD_W];
  end

  // Higher words are visited last, so they override lower ones.
  always_comb begin
    found = |word_any;
    idx   = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (word_any[w]) idx = IW'(w * WORD_W) | IW'(word_pos[w]);
    end
  end
endmodule

// File: rtl/ipc_vec_bank.sv
// One wide vector register with indexed clear and set (set wins).
module ipc_vec_bank #(
  parameter int WIDTH = 256,
  parameter int IW    = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_en,
  input  logic [IW-1:0]    clr_idx,
  input  logic             set_en,
  input  logic [IW-1:0]    set_idx,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] nxt;

  always_comb begin
    nxt = q;
    if (clr_en) nxt[clr_idx] = 1'b0;
    if (set_en) nxt[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/ipc_prio_eval.sv
// Processor priority and deliverability from class comparisons.
module ipc_prio_eval #(
  parameter int VEC_W = 8,
  parameter int CLS_W = VEC_W - 4
) (
  input  logic [VEC_W-1:0] tpr,
  input  logic             isr_any,
  input  logic [CLS_W-1:0] isr_cls_in,
  input  logic             irr_any,
  input  logic [CLS_W-1:0] irr_cls,
  output logic [VEC_W-1:0] ppr,
  output logic             deliverable
);
  logic [CLS_W-1:0] isr_cls;

  always_comb begin
    isr_cls = isr_any ? isr_cls_in : '0;
    if (tpr[VEC_W-1:4] >= isr_cls) ppr = tpr;
    else                           ppr = {isr_cls, 4'b0000};
    deliverable = irr_any && ((ppr == '0) || (irr_cls > ppr[VEC_W-1:4]));
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vector,
  input  logic             req_level,
  input  logic             tpr_we,
  input  logic [VEC_W-1:0] tpr_wdata,
  input  logic             svr_we,
  input  logic [VEC_W:0]   svr_wdata,
  input  logic             bcast_suppress,
  input  logic             ack_req,
  input  logic             eoi_req,
  output logic             irq_out,
  output logic [VEC_W-1:0] ppr_out,
  output logic             ack_valid,
  output logic [1:0]       ack_kind,
  output logic [VEC_W-1:0] ack_vector,
  output logic             bcast_valid,
  output logic [VEC_W-1:0] bcast_vector
);
  import ipc_pkg::*;

  localparam int CLS_W = VEC_W - 4;
  localparam logic [VEC_W:0] SVR_RST = {1'b0, {VEC_W{1'b1}}};

  logic [VEC_W-1:0]   tpr_q;
  logic [VEC_W:0]     svr_q;
  logic [NUM_VEC-1:0] tmr_q, irr_q, isr_q;

  logic               irr_any, isr_any;
  logic [VEC_W-1:0]   irr_top, isr_top;
  logic [VEC_W-1:0]   ppr_cur;
  logic               deliv;
  logic               sw_en, ack_take, eoi_fire;

  ipc_top_bit #(.WIDTH(NUM_VEC), .WORD_W(WORD_W), .IW(VEC_W)) u_irr_top (
    .vec(irr_q), .found(irr_any), .idx(irr_top)
  );
  ipc_top_bit #(.WIDTH(NUM_VEC), .WORD_W(WORD_W), .IW(VEC_W)) u_isr_top (
    .vec(isr_q), .found(isr_any), .idx(isr_top)
  );

  ipc_prio_eval #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_eval (
    .tpr(tpr_q), .isr_any(isr_any), .isr_cls_in(isr_top[VEC_W-1:4]),
    .irr_any(irr_any), .irr_cls(irr_top[VEC_W-1:4]),
    .ppr(ppr_cur), .deliverable(deliv)
  );

  assign sw_en    = svr_q[VEC_W];
  assign ack_take = ack_req && sw_en && deliv;
  assign eoi_fire = eoi_req && isr_any;

  // Pending: cleared by a taken acknowledge, set by a new request.
  ipc_vec_bank #(.WIDTH(NUM_VEC), .IW(VEC_W)) u_irr (
    .clk(clk), .rst(rst),
    .clr_en(ack_take), .clr_idx(irr_top),
    .set_en(req_valid), .set_idx(req_vector),
    .q(irr_q)
  );
  // In service: cleared by end-of-interrupt, set by a taken acknowledge.
  ipc_vec_bank #(.WIDTH(NUM_VEC), .IW(VEC_W)) u_isr (
    .clk(clk), .rst(rst),
    .clr_en(eoi_fire), .clr_idx(isr_top),
    .set_en(ack_take), .set_idx(irr_top),
    .q(isr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q <= '0;
      tpr_q <= '0;
      svr_q <= SVR_RST;
    end else begin
      if (req_valid) tmr_q[req_vector] <= req_level;
      if (tpr_we)    tpr_q <= tpr_wdata;
      if (svr_we)    svr_q <= svr_wdata;
    end
  end

  logic             irq_q, ack_valid_q, bcast_q;
  logic [VEC_W-1:0] ppr_q, ack_vec_q, bcast_vec_q;
  ack_kind_e        ack_kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q       <= 1'b0;
      ppr_q       <= '0;
      ack_valid_q <= 1'b0;
      ack_kind_q  <= ACK_NONE;
      ack_vec_q   <= '0;
      bcast_q     <= 1'b0;
      bcast_vec_q <= '0;
    end else begin
      irq_q       <= sw_en && deliv;
      ppr_q       <= ppr_cur;
      ack_valid_q <= ack_req;
      if (!ack_req || !sw_en || !irr_any) begin
        ack_kind_q <= ACK_NONE;
        ack_vec_q  <= '0;
      end else if (deliv) begin
        ack_kind_q <= ACK_VECTOR;
        ack_vec_q  <= irr_top;
      end else begin
        ack_kind_q <= ACK_SPURIOUS;
        ack_vec_q  <= svr_q[VEC_W-1:0];
      end
      bcast_q     <= eoi_fire && tmr_q[isr_top] && !bcast_suppress;
      bcast_vec_q <= eoi_fire ? isr_top : '0;
    end
  end

  assign irq_out      = irq_q;
  assign ppr_out      = ppr_q;
  assign ack_valid    = ack_valid_q;
  assign ack_kind     = ack_kind_q;
  assign ack_vector   = ack_vec_q;
  assign bcast_valid  = bcast_q;
  assign bcast_vector = bcast_vec_q;
endmodule

// File: rtl/ipc_chk.sv
module ipc_chk #(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               ack_req,
  input logic               eoi_req,
  input logic               irq_out,
  input logic               ack_valid,
  input logic [1:0]         ack_kind,
  input logic [VEC_W-1:0]   ack_vector,
  input logic               bcast_valid,
  input logic [VEC_W-1:0]   bcast_vector,
  input logic [VEC_W:0]     svr_q,
  input logic [NUM_VEC-1:0] isr_q
);
  assert_ack_follows_R5: assert property (@(posedge clk) disable iff (rst)
    ack_req |=> ack_valid);
  assert_ack_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !ack_req |=> !ack_valid);
  assert_ack_in_service_R5: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_kind == 2'd1) |-> isr_q[ack_vector]);
  assert_none_is_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_kind == 2'd0) |-> (ack_vector == '0));
  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(svr_q[VEC_W]));
  assert_bcast_after_eoi_R9: assert property (@(posedge clk) disable iff (rst)
    bcast_valid |-> $past(eoi_req));
  assert_bcast_retired_R9: assert property (@(posedge clk) disable iff (rst)
    bcast_valid |-> !isr_q[bcast_vector]);
endmodule

bind irq_prio_ctrl ipc_chk #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst(rst), .ack_req(ack_req), .eoi_req(eoi_req),
  .irq_out(irq_out), .ack_valid(ack_valid), .ack_kind(ack_kind),
  .ack_vector(ack_vector), .bcast_valid(bcast_valid),
  .bcast_vector(bcast_vector), .svr_q(svr_q), .isr_q(isr_q)
);

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_level = 1'b0;
  logic [7:0] req_vector = '0;
  logic       tpr_we = 1'b0;
  logic [7:0] tpr_wdata = '0;
  logic       svr_we = 1'b0;
  logic [8:0] svr_wdata = '0;
  logic       bcast_suppress = 1'b0;
  logic       ack_req = 1'b0, eoi_req = 1'b0;
  logic       irq_out, ack_valid, bcast_valid;
  logic [7:0] ppr_out, ack_vector, bcast_vector;
  logic [1:0] ack_kind;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vector(req_vector),
    .req_level(req_level), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
    .svr_we(svr_we), .svr_wdata(svr_wdata), .bcast_suppress(bcast_suppress),
    .ack_req(ack_req), .eoi_req(eoi_req), .irq_out(irq_out), .ppr_out(ppr_out),
    .ack_valid(ack_valid), .ack_kind(ack_kind), .ack_vector(ack_vector),
    .bcast_valid(bcast_valid), .bcast_vector(bcast_vector)
  );

  // Operations: 0 request, 1 task priority, 2 acknowledge, 3 end-of-interrupt, 4 spurious/enable
  typedef struct packed {
    logic [2:0] op;
    logic [8:0] arg;
    logic       lvl;
    logic       e_irq;
    logic [7:0] e_ppr;
    logic [1:0] e_kind;
    logic [7:0] e_vec;
    logic       e_bc;
    logic [7:0] e_bcv;
  } row_t;

  localparam int NROWS = 30;
  localparam row_t ROWS [NROWS] = '{
    '{3'd4, 9'h13F, 1'b0, 1'b0, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00}, // R10 enable
    '{3'd2, 9'h000, 1'b0, 1'b0, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00}, // R7 nothing pending
    '{3'd0, 9'h045, 1'b0, 1'b1, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00}, // R1
    '{3'd0, 9'h092, 1'b1, 1'b1, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00}, // R1 level
    '{3'd0, 9'h031, 1'b0, 1'b1, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00},
    '{3'd2, 9'h000, 1'b0, 1'b0, 8'h90, 2'd1, 8'h92, 1'b0, 8'h00}, // R2 R5
    '{3'd2, 9'h000, 1'b0, 1'b0, 8'h90, 2'd2, 8'h3F, 1'b0, 8'h00}, // R6 blocked
    '{3'd0, 9'h0A0, 1'b0, 1'b1, 8'h90, 2'd0, 8'h00, 1'b0, 8'h00}, // R4 higher class
    '{3'd2, 9'h000, 1'b0, 1'b0, 8'hA0, 2'd1, 8'hA0, 1'b0, 8'h00},
    '{3'd3, 9'h000, 1'b0, 1'b0, 8'h90, 2'd0, 8'h00, 1'b0, 8'h00}, // R8 edge, no pulse
    '{3'd3, 9'h000, 1'b0, 1'b1, 8'h00, 2'd0, 8'h00, 1'b1, 8'h92}, // R9 level pulse
    '{3'd1, 9'h050, 1'b0, 1'b0, 8'h50, 2'd0, 8'h00, 1'b0, 8'h00}, // R11
    '{3'd1, 9'h040, 1'b0, 1'b0, 8'h40, 2'd0, 8'h00, 1'b0, 8'h00}, // R4 equal class
    '{3'd1, 9'h03F, 1'b0, 1'b1, 8'h3F, 2'd0, 8'h00, 1'b0, 8'h00},
    '{3'd2, 9'h000, 1'b0, 1'b0, 8'h40, 2'd1, 8'h45, 1'b0, 8'h00}, // R3 isr class wins
    '{3'd3, 9'h000, 1'b0, 1'b0, 8'h3F, 2'd0, 8'h00, 1'b0, 8'h00},
    '{3'd1, 9'h000, 1'b0, 1'b1, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00},
    '{3'd4, 9'h03F, 1'b0, 1'b0, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00}, // R10 disable
    '{3'd2, 9'h000, 1'b0, 1'b0, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00}, // R10 ack none
    '{3'd4, 9'h13F, 1'b0, 1'b1, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00},
    '{3'd2, 9'h000, 1'b0, 1'b0, 8'h30, 2'd1, 8'h31, 1'b0, 8'h00},
    '{3'd3, 9'h000, 1'b0, 1'b0, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00},
    '{3'd3, 9'h000, 1'b0, 1'b0, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00}, // R13 empty
    '{3'd0, 9'h007, 1'b1, 1'b1, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00},
    '{3'd2, 9'h000, 1'b0, 1'b0, 8'h00, 2'd1, 8'h07, 1'b0, 8'h00},
    '{3'd3, 9'h000, 1'b0, 1'b0, 8'h00, 2'd0, 8'h00, 1'b1, 8'h07},
    '{3'd0, 9'h0C8, 1'b1, 1'b1, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00},
    '{3'd0, 9'h0C8, 1'b0, 1'b1, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00}, // R1 overwrite to edge
    '{3'd2, 9'h000, 1'b0, 1'b0, 8'hC0, 2'd1, 8'hC8, 1'b0, 8'h00},
    '{3'd3, 9'h000, 1'b0, 1'b0, 8'h00, 2'd0, 8'h00, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one operation for one cycle; returns at the negedge after the edge.
  task automatic do_op(input logic [2:0] op, input logic [8:0] arg, input logic lvl);
    req_valid  = (op == 3'd0);
    req_vector = arg[7:0];
    req_level  = lvl;
    tpr_we     = (op == 3'd1);
    tpr_wdata  = arg[7:0];
    ack_req    = (op == 3'd2);
    eoi_req    = (op == 3'd3);
    svr_we     = (op == 3'd4);
    svr_wdata  = arg;
    @(negedge clk);
    req_valid = 1'b0; tpr_we = 1'b0; ack_req = 1'b0; eoi_req = 1'b0; svr_we = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 irq_out", irq_out, 0);
    chk("R12 ppr_out", ppr_out, 0);
    chk("R12 ack_valid", ack_valid, 0);
    chk("R12 bcast_valid", bcast_valid, 0);
    do_op(3'd2, 9'h0, 1'b0);
    chk("R12 disabled after reset ack_kind", ack_kind, 0);

    // Table walk
    for (int i = 0; i < NROWS; i++) begin
      do_op(ROWS[i].op, ROWS[i].arg, ROWS[i].lvl);
      if (ROWS[i].op == 3'd2) begin
        chk($sformatf("R5 row%0d ack_valid", i), ack_valid, 1);
        chk($sformatf("R5 row%0d ack_kind", i), ack_kind, ROWS[i].e_kind);
        chk($sformatf("R5 row%0d ack_vector", i), ack_vector, ROWS[i].e_vec);
      end
      chk($sformatf("R9 row%0d bcast_valid", i), bcast_valid, ROWS[i].e_bc);
      if (ROWS[i].e_bc) chk($sformatf("R9 row%0d bcast_vector", i), bcast_vector, ROWS[i].e_bcv);
      idle();
      chk($sformatf("R4 row%0d irq_out", i), irq_out, ROWS[i].e_irq);
      chk($sformatf("R3 row%0d ppr_out", i), ppr_out, ROWS[i].e_ppr);
    end

    // R2 word boundary 0x1F / 0x20
    do_op(3'd0, 9'h01F, 1'b0);
    do_op(3'd0, 9'h020, 1'b0);
    do_op(3'd2, 9'h0, 1'b0);
    chk("R2 boundary first ack", ack_vector, 8'h20);
    do_op(3'd3, 9'h0, 1'b0);
    do_op(3'd2, 9'h0, 1'b0);
    chk("R2 boundary second ack", ack_vector, 8'h1F);
    do_op(3'd3, 9'h0, 1'b0);
    // R2 extremes 0xFF / 0x00
    do_op(3'd0, 9'h000, 1'b0);
    do_op(3'd0, 9'h0FF, 1'b0);
    do_op(3'd2, 9'h0, 1'b0);
    chk("R2 top vector ack", ack_vector, 8'hFF);
    do_op(3'd3, 9'h0, 1'b0);
    do_op(3'd2, 9'h0, 1'b0);
    chk("R2 vector zero kind", ack_kind, 1);
    chk("R2 vector zero value", ack_vector, 8'h00);
    do_op(3'd3, 9'h0, 1'b0);

    // R9 suppress control
    bcast_suppress = 1'b1;
    do_op(3'd0, 9'h060, 1'b1);
    do_op(3'd2, 9'h0, 1'b0);
    chk("R9 suppress ack", ack_vector, 8'h60);
    do_op(3'd3, 9'h0, 1'b0);
    chk("R9 suppressed pulse", bcast_valid, 0);
    idle();
    chk("R8 ppr after suppressed eoi", ppr_out, 0);
    bcast_suppress = 1'b0;

    // R12 reset mid-run clears pending state
    do_op(3'd0, 9'h088, 1'b1);
    idle();
    chk("R4 irq before reset", irq_out, 1);
    rst = 1'b1;
    idle(); idle();
    rst = 1'b0;
    idle();
    chk("R12 irq after reset", irq_out, 0);
    do_op(3'd4, 9'h13F, 1'b0);
    do_op(3'd2, 9'h0, 1'b0);
    chk("R12 pending cleared", ack_kind, 0);
    do_op(3'd3, 9'h0, 1'b0);
    chk("R13 no pulse after reset", bcast_valid, 0);

    finish_run();
  end
endmodule